// File: doc/BRIEF.md
# Pulse Width Capture Timer

This block is one timer channel that measures how long an input signal stays at a chosen level. Software, or a controlling block, writes a start trigger to arm the channel. The channel then waits for the edge that begins the chosen level. It clears its counter and counts timer ticks until the opposite edge arrives. At that edge it copies the count into a capture register, pulses an interrupt and updates an overflow flag. The counter then freezes, and the channel waits for the next start edge to measure again.

The measured input first passes through a synchronizer. An optional glitch filter can follow it; the filter only passes a level once that level has been stable for a set number of clocks. A level-select bit picks whether high pulses or low pulses are measured. The level-select and filter bits only take effect when written while the channel is stopped. A stop trigger halts the channel and leaves the count and the overflow flag untouched. A tick-enable input stands in for a prescaled timer clock.

Top module: `pwcap_timer`

## Requirements
- R1: A write with `cmd_start`=1 and `cmd_stop`=0 sets `enabled` to 1. `trig_rb` shows the written trigger bits (bit 0 = start, bit 1 = stop) for exactly one cycle after a write, and reads 0 in every cycle that does not follow a write.
- R2: After the channel is enabled, `count` does not change until a start edge is seen on the filtered input, even while `tick_en` is high.
- R3: On a start edge `count` is cleared to 0, and it then adds one for each cycle with `tick_en`=1. With `tick_en` held high, `capture` equals the pulse width in clock cycles. With `tick_en` held low, `capture` is 0.
- R4: At each capture edge, `capture` is loaded and `irq` is high for exactly one cycle. `capture` never changes in a cycle without `irq`.
- R5: At each capture, `ovf` is set to 1 if `count` rolled over from all ones to zero during that measurement, and set to 0 otherwise. `ovf` changes only in a cycle with `irq`.
- R6: After a capture, `count` holds the captured value until the next start edge.
- R7: A write with `cmd_stop`=1 clears `enabled`. This takes priority over `cmd_start`. While the channel is disabled, `count` and `ovf` hold their values and no capture or `irq` occurs.
- R8: Writes to `cfg_level` and `cfg_filt` are ignored while `enabled`=1, so `level_q` and `filt_q` keep their values.
- R9: `level_q`=0 measures a high pulse (rising start, falling capture). `level_q`=1 measures a low pulse (falling start, rising capture).
- R10: With `filt_q`=1, an input pulse shorter than FILT_LEN (2) clocks is rejected and produces no capture, while a 2-clock pulse measures as 2. With `filt_q`=0, a 1-clock pulse measures as 1.
- R11: After reset, `enabled`, `trig_rb`, `level_q`, `filt_q`, `count`, `capture`, `ovf` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer tick; the counter advances in cycles where it is 1 |
| sig_in | input | 1 | Asynchronous signal being measured |
| cmd_we | input | 1 | Control write strobe |
| cmd_start | input | 1 | Start trigger bit of the write |
| cmd_stop | input | 1 | Stop trigger bit of the write |
| cfg_level | input | 1 | Level select of the write (0 high pulse, 1 low pulse) |
| cfg_filt | input | 1 | Glitch filter enable of the write |
| enabled | output | 1 | Channel running |
| trig_rb | output | 2 | Trigger readback {stop, start}, self-clearing |
| level_q | output | 1 | Active level select |
| filt_q | output | 1 | Active filter enable |
| count | output | CNT_W | Live counter value |
| capture | output | CNT_W | Last captured width |
| ovf | output | 1 | Overflow status of the last capture |
| irq | output | 1 | One-cycle capture interrupt |

## Verification
The assertions check the following on every cycle: `irq` lasts one cycle; `capture` and `ovf` move only with `irq`; the trigger readback clears whenever no write is made; the configuration bits stay fixed while the channel runs; and `count` stays frozen while the channel is stopped. Some behaviours can only be shown by the bench's scenarios, because they depend on the signal history. These are the measured width itself, the overflow across a 65540-cycle pulse and a 65535-cycle pulse, the glitch rejection of the filter, the reversed polarity, the count held between captures, and the interrupt that is suppressed when a stop arrives in the middle of a pulse.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;
  typedef enum logic {
    MEAS_HIGH = 1'b0,
    MEAS_LOW  = 1'b1
  } pw_level_e;

  typedef struct packed {
    logic stop;
    logic start;
  } pw_trig_t;
endpackage

// File: rtl/pwcap_insync.sv
module pwcap_insync #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic filt_en,
  output logic dout
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync_q[i] <= 1'b0;
      else     sync_q[i] <= (i == 0) ? din : sync_q[(i == 0) ? 0 : i-1];
    end
  end

  wire s_lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      dout   <= 1'b0;
    end else begin
      hist_q <= {hist_q[FILT_LEN-2:0], s_lvl};
      if (!filt_en)             dout <= s_lvl;
      else if (hist_q == '1)    dout <= 1'b1;
      else if (hist_q == '0)    dout <= 1'b0;
    end
  end
endmodule

// File: rtl/pwcap_edge.sv
module pwcap_edge
  import pwcap_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      lvl,
  input  pw_level_e sel,
  output logic      start_ev,
  output logic      cap_ev
);
  logic lvl_d;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else     lvl_d <= lvl;
  end

  wire rise = lvl & ~lvl_d;
  wire fall = ~lvl & lvl_d;

  always_comb begin
    if (sel == MEAS_LOW) begin
      start_ev = fall;
      cap_ev   = rise;
    end else begin
      start_ev = rise;
      cap_ev   = fall;
    end
  end
endmodule

// File: rtl/pwcap_ctrl.sv
module pwcap_ctrl
  import pwcap_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      we,
  input  pw_trig_t  trig,
  input  logic      cfg_level,
  input  logic      cfg_filt,
  output logic      en,
  output logic      arm,
  output pw_trig_t  trig_q,
  output pw_level_e level_q,
  output logic      filt_q
);
  assign arm = we & trig.start & ~trig.stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      en      <= 1'b0;
      trig_q  <= '0;
      level_q <= MEAS_HIGH;
      filt_q  <= 1'b0;
    end else begin
      trig_q <= we ? trig : '0;
      if (we) begin
        if (trig.stop)       en <= 1'b0;
        else if (trig.start) en <= 1'b1;
        if (!en) begin
          level_q <= pw_level_e'(cfg_level);
          filt_q  <= cfg_filt;
        end
      end
    end
  end
endmodule

// File: rtl/pwcap_meas.sv
module pwcap_meas #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             arm,
  input  logic             tick,
  input  logic             start_ev,
  input  logic             cap_ev,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capture,
  output logic             ovf,
  output logic             irq
);
  logic meas_q;
  logic wrap_q;

  wire [CNT_W-1:0] nxt   = count + CNT_W'(tick);
  wire             carry = tick & (count == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      meas_q  <= 1'b0;
      wrap_q  <= 1'b0;
      count   <= '0;
      capture <= '0;
      ovf     <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (!en || arm) begin
        meas_q <= 1'b0;
      end else if (!meas_q) begin
        if (start_ev) begin
          count  <= '0;
          wrap_q <= 1'b0;
          meas_q <= 1'b1;
        end
      end else if (cap_ev) begin
        count   <= nxt;
        capture <= nxt;
        ovf     <= wrap_q | carry;
        irq     <= 1'b1;
        meas_q  <= 1'b0;
      end else begin
        count  <= nxt;
        wrap_q <= wrap_q | carry;
      end
    end
  end
endmodule

// File: rtl/pwcap_timer.sv
module pwcap_timer
  import pwcap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             sig_in,
  input  logic             cmd_we,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             cfg_level,
  input  logic             cfg_filt,
  output logic             enabled,
  output logic [1:0]       trig_rb,
  output logic             level_q,
  output logic             filt_q,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capture,
  output logic             ovf,
  output logic             irq
);
  pw_trig_t  trig_in, trig_q;
  pw_level_e lvl_sel;
  logic      arm, filt_lvl, start_ev, cap_ev;

  assign trig_in = '{stop: cmd_stop, start: cmd_start};
  assign trig_rb = trig_q;
  assign level_q = lvl_sel;

  pwcap_ctrl u_ctrl (
    .clk(clk), .rst(rst), .we(cmd_we), .trig(trig_in),
    .cfg_level(cfg_level), .cfg_filt(cfg_filt),
    .en(enabled), .arm(arm), .trig_q(trig_q),
    .level_q(lvl_sel), .filt_q(filt_q)
  );

  pwcap_insync #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_insync (
    .clk(clk), .rst(rst), .din(sig_in), .filt_en(filt_q), .dout(filt_lvl)
  );

  pwcap_edge u_edge (
    .clk(clk), .rst(rst), .lvl(filt_lvl), .sel(lvl_sel),
    .start_ev(start_ev), .cap_ev(cap_ev)
  );

  pwcap_meas #(.CNT_W(CNT_W)) u_meas (
    .clk(clk), .rst(rst), .en(enabled), .arm(arm), .tick(tick_en),
    .start_ev(start_ev), .cap_ev(cap_ev),
    .count(count), .capture(capture), .ovf(ovf), .irq(irq)
  );
endmodule

// File: rtl/pwcap_chk.sv
module pwcap_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_we,
  input logic             enabled,
  input logic [1:0]       trig_rb,
  input logic             level_q,
  input logic             filt_q,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] capture,
  input logic             ovf,
  input logic             irq
);
  // R1
  trig_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_we |=> trig_rb == 2'b00);

  // R4
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R4
  capture_on_irq_chk: assert property (@(posedge clk) disable iff (rst)
    !irq |=> $stable(capture) || irq);

  // R5
  ovf_on_irq_chk: assert property (@(posedge clk) disable iff (rst)
    !irq |=> $stable(ovf) || irq);

  // R7
  count_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !enabled |=> $stable(count));

  // R8
  cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
    enabled |=> $stable(level_q) && $stable(filt_q));
endmodule

bind pwcap_timer pwcap_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_we(cmd_we), .enabled(enabled),
  .trig_rb(trig_rb), .level_q(level_q), .filt_q(filt_q),
  .count(count), .capture(capture), .ovf(ovf), .irq(irq)
);

// File: tb/pwcap_timer_tb.sv
module pwcap_timer_tb;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b1, sig_in = 1'b0;
  logic cmd_we = 1'b0, cmd_start = 1'b0, cmd_stop = 1'b0;
  logic cfg_level = 1'b0, cfg_filt = 1'b0;
  logic enabled, level_q, filt_q, ovf, irq;
  logic [1:0] trig_rb;
  logic [CW-1:0] count, capture;

  int n_tests = 0, n_fail = 0, irq_cnt = 0;

  always #10 clk = ~clk;

  pwcap_timer #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .sig_in(sig_in),
    .cmd_we(cmd_we), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cfg_level(cfg_level), .cfg_filt(cfg_filt),
    .enabled(enabled), .trig_rb(trig_rb), .level_q(level_q), .filt_q(filt_q),
    .count(count), .capture(capture), .ovf(ovf), .irq(irq)
  );

  always @(negedge clk) if (irq) irq_cnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic st, input logic sp, input logic lv, input logic fl);
    @(negedge clk);
    cmd_we = 1'b1; cmd_start = st; cmd_stop = sp; cfg_level = lv; cfg_filt = fl;
    @(negedge clk);
    cmd_we = 1'b0; cmd_start = 1'b0; cmd_stop = 1'b0;
  endtask

  // drive the active level for w cycles, then wait for irq
  task automatic pulse(input logic act, input int w, output bit got);
    got = 1'b0;
    @(negedge clk);
    sig_in = act;
    repeat (w) @(negedge clk);
    sig_in = ~act;
    for (int i = 0; i < 30; i++) begin
      if (irq) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  function automatic logic [CW-1:0] exp_width(input int w, input logic tk);
    return tk ? CW'(w) : '0;
  endfunction

  function automatic logic exp_ovf(input int w, input logic tk);
    return tk && (w > (1 << CW) - 1);
  endfunction

  task automatic measure(input string req, input logic act, input int w);
    bit got;
    pulse(act, w, got);
    check({req, " irq seen"}, got, 1);
    check({req, " capture"}, capture, exp_width(w, tick_en));
    check({req, " ovf"}, ovf, exp_ovf(w, tick_en));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int base_irq;
    logic [CW-1:0] held;
    bit got;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 enabled", enabled, 0);
    check("R11 trig_rb", trig_rb, 0);
    check("R11 cfg", {level_q, filt_q}, 0);
    check("R11 count", count, 0);
    check("R11 capture/ovf/irq", {capture, ovf, irq}, 0);

    // R1 start trigger
    @(negedge clk);
    cmd_we = 1'b1; cmd_start = 1'b1; cfg_level = 1'b0; cfg_filt = 1'b0;
    @(negedge clk);
    cmd_we = 1'b0; cmd_start = 1'b0;
    check("R1 enabled", enabled, 1);
    check("R1 trig_rb start", trig_rb, 2'b01);
    @(negedge clk);
    check("R1 trig_rb self-clear", trig_rb, 0);

    // R2 no counting before start edge
    repeat (10) @(negedge clk);
    check("R2 count idle", count, 0);

    // R5 R3 overflow across wrap
    measure("R5 long", 1'b1, 65540);
    // R6 held after capture
    held = capture;
    repeat (5) @(negedge clk);
    check("R6 count held", count, held);

    // R7 stop mid-pulse
    @(negedge clk); sig_in = 1'b1;
    repeat (20) @(negedge clk);
    wr(1'b0, 1'b1, 1'b0, 1'b0);
    check("R7 disabled", enabled, 0);
    check("R1 trig_rb stop", trig_rb, 2'b10);
    held = count;
    base_irq = irq_cnt;
    repeat (10) @(negedge clk);
    sig_in = 1'b0;
    repeat (20) @(negedge clk);
    check("R7 count held", count, held);
    check("R7 no irq", irq_cnt, base_irq);
    check("R7 ovf held", ovf, 1);

    // R5 just below wrap clears ovf
    wr(1'b1, 1'b0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    measure("R5 max", 1'b1, 65535);

    // R8 config ignored while enabled
    wr(1'b0, 1'b0, 1'b1, 1'b1);
    check("R8 level_q", level_q, 0);
    check("R8 filt_q", filt_q, 0);
    repeat (5) @(negedge clk);
    measure("R8 high pulse", 1'b1, 7);

    // R3 tick held low
    tick_en = 1'b0;
    repeat (5) @(negedge clk);
    measure("R3 no tick", 1'b1, 10);
    tick_en = 1'b1;

    // R10 filter on
    wr(1'b0, 1'b1, 1'b0, 1'b0);
    wr(1'b1, 1'b0, 1'b0, 1'b1);
    check("R10 filt_q", filt_q, 1);
    repeat (8) @(negedge clk);
    base_irq = irq_cnt;
    pulse(1'b1, 1, got);
    check("R10 glitch rejected", irq_cnt, base_irq);
    repeat (5) @(negedge clk);
    measure("R10 two-cycle", 1'b1, 2);

    // R10 filter off
    wr(1'b0, 1'b1, 1'b0, 1'b0);
    wr(1'b1, 1'b0, 1'b0, 1'b0);
    repeat (8) @(negedge clk);
    measure("R10 single unfiltered", 1'b1, 1);

    // R9 low pulse polarity
    wr(1'b0, 1'b1, 1'b0, 1'b0);
    sig_in = 1'b1;
    repeat (10) @(negedge clk);
    wr(1'b1, 1'b0, 1'b1, 1'b0);
    check("R9 level_q", level_q, 1);
    repeat (5) @(negedge clk);
    measure("R9 low pulse", 1'b0, 9);

    // random widths, levels and filter settings
    for (int k = 0; k < 12; k++) begin
      logic lv, fl;
      int w;
      lv = 1'($urandom % 2);
      fl = 1'($urandom % 2);
      w  = 2 + int'($urandom % 50);
      wr(1'b0, 1'b1, 1'b0, 1'b0);
      sig_in = lv;
      repeat (8) @(negedge clk);
      wr(1'b1, 1'b0, lv, fl);
      repeat (4) @(negedge clk);
      measure("R3 R9 random", ~lv, w);
      held = capture;
      repeat (3) @(negedge clk);
      check("R6 random hold", count, held);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule